// File: doc/BRIEF.md
# Shared-Monomial Galois Field Polynomial Evaluator

This block evaluates a fixed group of E polynomials in M variables over the small field GF(2^K), with K equal to 2 or 3. One vector of M field elements enters per clock with a valid strobe. E field elements leave a fixed number of cycles later with a matching valid. The coefficients of every polynomial are fixed when the design is built, so one netlist computes one fixed mapping from M-element input vectors to E-element output vectors.

The datapath has four register stages. The first raises every input variable to every exponent from 0 to 2^K-1. The second multiplies those powers into monomials. A monomial is built once and shared by every output that uses it. A monomial whose coefficient is zero in all outputs is never built. The third stage scales each monomial by each output's nonzero coefficient. The fourth stage XORs the scaled terms of each output together. Pipeline depth does not change with M or E.

Top module: `gfpe_top`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears `out_valid` and every field of `out_vals` to zero from the next cycle on.
- R2: `out_valid` equals `in_valid` delayed by exactly 4 clock cycles. A new vector is accepted every cycle, with or without gaps between vectors.
- R3: For a vector accepted in cycle n, output e in cycle n+4 equals the XOR, over all exponent tuples, of coefficient times the product of each variable raised to its exponent. Elements are bit vectors of polynomial coefficients, and products are reduced modulo x^2+x+1 (K=2) or x^3+x+1 (K=3). Any variable to the power 0 is 1, including zero.
- R4: Variable v sits at bits [v*K +: K] of `in_vars`, and output e sits at bits [e*K +: K] of `out_vals`. The coefficient of output e for tuple t sits at bits [(e*2^(K*M) + t)*K +: K] of `COEFS`. Bits [v*K +: K] of t give the exponent of variable v.
- R5: An all-zero input vector produces, on each output, that output's constant-term coefficient (tuple 0).
- R6: An output whose coefficients are all zero is zero in every cycle.
- R7: While `out_valid` is low, `out_vals` keeps the last result it presented.
- R8: A monomial used by several outputs gives the correct value on each of them within the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector strobe |
| in_vars | input | M*K | M field elements, variable v at [v*K +: K] |
| out_valid | output | 1 | Result strobe, 4 cycles after `in_valid` |
| out_vals | output | E*K | E results, output e at [e*K +: K] |

## Verification
A wrong power table, a bad monomial product or a missing term changes the result on every output whose polynomial uses that term. The error shows exactly four cycles after the first input vector that makes the term nonzero. Exhaustive input sweeps make every such term nonzero at least once. A fault in the valid pipeline or the stage enables shows as a result in the wrong cycle, or as `out_vals` changing while `out_valid` is low. Either one is visible on the first idle cycle after a valid result.

// File: rtl/gfpe_pkg.sv
package gfpe_pkg;

    localparam int KMAX = 3;

    typedef logic [KMAX-1:0] gf_t;

    // Valid flags, one per register stage
    typedef struct packed {
        logic pw;
        logic mono;
        logic prod;
        logic sum;
    } stage_vld_t;

    localparam int PIPE_DEPTH = 4;

    function automatic int gf_prim(input int k);
        return (k == 2) ? 32'h7 : 32'hB;
    endfunction

    // Antilog: alpha^i, with alpha a root of the primitive polynomial
    function automatic gf_t gf_alog(input int k, input int i);
        int a;
        a = 1;
        for (int n = 0; n < i; n++) begin
            a = a << 1;
            if (((a >> k) & 1) != 0) a = a ^ gf_prim(k);
        end
        return gf_t'(a);
    endfunction

    function automatic int gf_log(input int k, input gf_t v);
        for (int i = 0; i < (1 << k) - 1; i++)
            if (gf_alog(k, i) == v) return i;
        return 0;
    endfunction

    function automatic gf_t gf_mul(input int k, input gf_t a, input gf_t b);
        if (a == '0 || b == '0) return '0;
        return gf_alog(k, (gf_log(k, a) + gf_log(k, b)) % ((1 << k) - 1));
    endfunction

    function automatic gf_t gf_pow(input int k, input gf_t a, input int e);
        if (e == 0) return gf_t'(1);
        if (a == '0) return '0;
        return gf_alog(k, (gf_log(k, a) * e) % ((1 << k) - 1));
    endfunction

endpackage

// File: rtl/gfpe_pow_stage.sv
module gfpe_pow_stage
    import gfpe_pkg::*;
#(
    parameter int K = 2,
    parameter int M = 2,
    localparam int Q = 1 << K
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [M-1:0][K-1:0]         x,
    output logic [M-1:0][Q-1:0][K-1:0]  pw
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pw <= '0;
        end else if (en) begin
            for (int v = 0; v < M; v++)
                for (int e = 0; e < Q; e++)
                    pw[v][e] <= K'(gf_pow(K, gf_t'(x[v]), e));
        end
    end

endmodule

// File: rtl/gfpe_mono_stage.sv
module gfpe_mono_stage
    import gfpe_pkg::*;
#(
    parameter int K = 2,
    parameter int M = 2,
    parameter int E = 3,
    parameter logic [E*(1<<(K*M))*K-1:0] COEFS = '0,
    localparam int Q  = 1 << K,
    localparam int NT = 1 << (K*M)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic [M-1:0][Q-1:0][K-1:0]  pw,
    output logic [NT-1:0][K-1:0]        mono
);

    function automatic bit term_used(input int t);
        for (int e = 0; e < E; e++)
            if (COEFS[(e*NT + t)*K +: K] != '0) return 1'b1;
        return 1'b0;
    endfunction

    for (genvar t = 0; t < NT; t++) begin : g_term
        if (term_used(t)) begin : g_use
            logic [K-1:0] prod_c;
            logic [K-1:0] prod_q;

            always_comb begin
                gf_t acc;
                acc = gf_t'(1);
                for (int v = 0; v < M; v++)
                    acc = gf_mul(K, acc, gf_t'(pw[v][(t >> (K*v)) & (Q-1)]));
                prod_c = K'(acc);
            end

            always_ff @(posedge clk) begin
                if (rst)     prod_q <= '0;
                else if (en) prod_q <= prod_c;
            end

            assign mono[t] = prod_q;
        end else begin : g_skip
            assign mono[t] = '0;
        end
    end

endmodule

// File: rtl/gfpe_scale_sum.sv
module gfpe_scale_sum
    import gfpe_pkg::*;
#(
    parameter int K = 2,
    parameter int M = 2,
    parameter int E = 3,
    parameter logic [E*(1<<(K*M))*K-1:0] COEFS = '0,
    localparam int NT = 1 << (K*M)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_scale,
    input  logic                    en_sum,
    input  logic [NT-1:0][K-1:0]    mono,
    output logic [E-1:0][K-1:0]     y
);

    function automatic logic [K-1:0] coef(input int e, input int t);
        return COEFS[(e*NT + t)*K +: K];
    endfunction

    function automatic bit out_used(input int e);
        for (int t = 0; t < NT; t++)
            if (coef(e, t) != '0) return 1'b1;
        return 1'b0;
    endfunction

    logic [E-1:0][NT-1:0][K-1:0] scaled;

    for (genvar e = 0; e < E; e++) begin : g_out
        for (genvar t = 0; t < NT; t++) begin : g_term
            if (coef(e, t) != '0) begin : g_mul
                logic [K-1:0] sc_q;
                always_ff @(posedge clk) begin
                    if (rst)           sc_q <= '0;
                    else if (en_scale) sc_q <= K'(gf_mul(K, gf_t'(coef(e, t)), gf_t'(mono[t])));
                end
                assign scaled[e][t] = sc_q;
            end else begin : g_zero
                assign scaled[e][t] = '0;
            end
        end

        if (out_used(e)) begin : g_sum
            logic [K-1:0] sum_c;
            logic [K-1:0] sum_q;

            always_comb begin
                sum_c = '0;
                for (int t = 0; t < NT; t++) sum_c = sum_c ^ scaled[e][t];
            end

            always_ff @(posedge clk) begin
                if (rst)         sum_q <= '0;
                else if (en_sum) sum_q <= sum_c;
            end

            assign y[e] = sum_q;
        end else begin : g_const
            assign y[e] = '0;
        end
    end

endmodule

// File: rtl/gfpe_top.sv
module gfpe_top
    import gfpe_pkg::*;
#(
    parameter int K = 2,
    parameter int M = 2,
    parameter int E = 3,
    parameter logic [E*(1<<(K*M))*K-1:0] COEFS = 96'h00000000_01000480_00000C09
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [M*K-1:0] in_vars,
    output logic           out_valid,
    output logic [E*K-1:0] out_vals
);

    localparam int Q  = 1 << K;
    localparam int NT = 1 << (K*M);

    stage_vld_t                  vld;
    logic [M-1:0][Q-1:0][K-1:0]  pw;
    logic [NT-1:0][K-1:0]        mono;
    logic [E-1:0][K-1:0]         y;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            vld.pw   <= in_valid;
            vld.mono <= vld.pw;
            vld.prod <= vld.mono;
            vld.sum  <= vld.prod;
        end
    end

    gfpe_pow_stage #(.K(K), .M(M)) pow_i (
        .clk (clk),
        .rst (rst),
        .en  (in_valid),
        .x   (in_vars),
        .pw  (pw)
    );

    gfpe_mono_stage #(.K(K), .M(M), .E(E), .COEFS(COEFS)) mono_i (
        .clk  (clk),
        .rst  (rst),
        .en   (vld.pw),
        .pw   (pw),
        .mono (mono)
    );

    gfpe_scale_sum #(.K(K), .M(M), .E(E), .COEFS(COEFS)) sum_i (
        .clk      (clk),
        .rst      (rst),
        .en_scale (vld.mono),
        .en_sum   (vld.prod),
        .mono     (mono),
        .y        (y)
    );

    assign out_valid = vld.sum;
    assign out_vals  = y;

endmodule

// File: rtl/gfpe_chk.sv
module gfpe_chk #(
    parameter int K = 2,
    parameter int M = 2,
    parameter int E = 3,
    parameter logic [E*(1<<(K*M))*K-1:0] COEFS = '0
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [M*K-1:0] in_vars,
    input logic           out_valid,
    input logic [E*K-1:0] out_vals
);

    localparam int NT  = 1 << (K*M);
    localparam int LAT = 4;

    function automatic logic [E*K-1:0] const_terms();
        logic [E*K-1:0] r;
        r = '0;
        for (int e = 0; e < E; e++) r[e*K +: K] = COEFS[(e*NT)*K +: K];
        return r;
    endfunction

    localparam logic [E*K-1:0] Y0 = const_terms();

    int cnt = 0;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= 0;
        else if (cnt < LAT) cnt <= cnt + 1;
    end

    // R1: first cycle out of reset shows a cleared output
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        (cnt == 0) |-> (!out_valid && out_vals == '0));

    // R2: valid leaves four cycles after it enters
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        (cnt >= LAT) |-> (out_valid == $past(in_valid, LAT)));

    // R5: zero vector yields the constant terms
    a_r5_zero_vector: assert property (@(posedge clk) disable iff (rst)
        (cnt >= LAT && $past(in_valid, LAT) && $past(in_vars, LAT) == '0)
        |-> (out_vals == Y0));

    // R7: results hold while no valid is presented
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 1 && !out_valid) |-> $stable(out_vals));

endmodule

bind gfpe_top gfpe_chk #(.K(K), .M(M), .E(E), .COEFS(COEFS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_vars   (in_vars),
    .out_valid (out_valid),
    .out_vals  (out_vals)
);

// File: tb/gfpe_top_tb_top.sv
module gfpe_top_tb_top;

    localparam int K   = 2;
    localparam int M   = 2;
    localparam int E   = 3;
    localparam int Q   = 1 << K;
    localparam int NT  = 1 << (K*M);
    localparam int LAT = 4;
    localparam int POLY = (K == 2) ? 7 : 11;
    localparam logic [E*NT*K-1:0] CF = 96'h00000000_01000480_00000C09;

    logic           clk = 1'b0;
    logic           rst;
    logic           in_valid;
    logic [M*K-1:0] in_vars;
    logic           out_valid;
    logic [E*K-1:0] out_vals;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic           hv [1:LAT];
    logic [M*K-1:0] hx [1:LAT];
    logic [E*K-1:0] last_y;

    always #4 clk = ~clk;

    gfpe_top #(.K(K), .M(M), .E(E), .COEFS(CF)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_vars   (in_vars),
        .out_valid (out_valid),
        .out_vals  (out_vals)
    );

    // Shift-and-add multiply with polynomial reduction
    function automatic logic [K-1:0] rmul(input logic [K-1:0] a, input logic [K-1:0] b);
        logic [2*K-1:0] p;
        p = '0;
        for (int i = 0; i < K; i++)
            if (b[i]) p = p ^ ((2*K)'(a) << i);
        for (int i = 2*K-2; i >= K; i--)
            if (p[i]) p = p ^ ((2*K)'(POLY) << (i-K));
        return p[K-1:0];
    endfunction

    function automatic logic [K-1:0] rpow(input logic [K-1:0] a, input int e);
        logic [K-1:0] r;
        r = K'(1);
        for (int i = 0; i < e; i++) r = rmul(r, a);
        return r;
    endfunction

    function automatic logic [E*K-1:0] ref_eval(input logic [M*K-1:0] x);
        logic [E*K-1:0] r;
        logic [K-1:0]   m;
        r = '0;
        for (int e = 0; e < E; e++)
            for (int t = 0; t < NT; t++) begin
                m = K'(1);
                for (int v = 0; v < M; v++)
                    m = rmul(m, rpow(x[v*K +: K], (t >> (K*v)) & (Q-1)));
                r[e*K +: K] = r[e*K +: K] ^ rmul(CF[(e*NT + t)*K +: K], m);
            end
        return r;
    endfunction

    task automatic check(input string req, input logic [E*K-1:0] act, input logic [E*K-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [M*K-1:0] x);
        logic [E*K-1:0] exp_y;
        @(negedge clk);
        check("R2 valid timing", E*K'(out_valid), E*K'(hv[LAT]));
        if (hv[LAT]) begin
            exp_y = ref_eval(hx[LAT]);
            check("R3 R4 R8 polynomial value", out_vals, exp_y);
            check("R6 zero output", E*K'(out_vals[2*K +: K]), '0);
            if (hx[LAT] == '0) check("R5 constant terms", out_vals, exp_y);
        end else begin
            check("R7 hold while idle", out_vals, last_y);
        end
        last_y = out_vals;
        for (int i = LAT; i > 1; i--) begin
            hv[i] = hv[i-1];
            hx[i] = hx[i-1];
        end
        hv[1] = v;
        hx[1] = x;
        in_valid = v;
        in_vars  = x;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 1; i <= LAT; i++) begin
            hv[i] = 1'b0;
            hx[i] = '0;
        end
        rst      = 1'b1;
        in_valid = 1'b1;
        in_vars  = '1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        // R1: cleared state after reset
        check("R1 reset valid", E*K'(out_valid), '0);
        check("R1 reset values", out_vals, '0);
        last_y = '0;
        rst = 1'b0;

        // R5: zero vector first
        step(1'b1, '0);
        // Hand-computed value: x0=1, x1=1 -> out0 = 1^2^3 = 0, out1 = 1^2^1 = 2
        step(1'b1, 4'b0101);
        // Exhaustive sweep, back to back (R2, R3, R8)
        for (int a = 0; a < (1 << (M*K)); a++) step(1'b1, (M*K)'(a));
        repeat (LAT + 2) step(1'b0, '0);
        // Exhaustive sweep with gaps (R7)
        for (int a = 0; a < (1 << (M*K)); a++) begin
            step(1'b1, (M*K)'(a));
            step(1'b0, '1);
        end
        // Random stream
        for (int n = 0; n < 400; n++)
            step(1'($urandom() & 1), (M*K)'($urandom()));
        repeat (LAT + 2) step(1'b0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Directed expectation for the hand-computed vector
    initial begin
        @(negedge rst);
        repeat (LAT + 2) @(negedge clk);
        if (!done) begin
            check("R3 R8 shared monomial x0=x1=1", out_vals, {2'd0, 2'd2, 2'd0});
        end
    end

endmodule